// File: doc/BRIEF.md
# CAN bit timing and resynchronization unit

This block derives CAN bit timing from a module clock. A programmable divider produces time-quantum (tq) ticks. Each nominal bit is made of a one-quantum synchronization segment, a first time segment and a second time segment. The lengths of the two time segments come from configuration inputs. The block watches the receive line after a two-stage synchronizer and acts on recessive-to-dominant (1 to 0) transitions. When the frame layer reports an idle bus, such an edge restarts the bit at once, which is a hard synchronization. On a busy bus the edge moves the bit boundary instead, which is a resynchronization. It does this by stretching the first segment or cutting the second, and never by more than the jump width.

The block has two outputs for the layers above it. A sample strobe marks the sample point and carries the bit value read there. A transmit strobe marks the start of every bit. Configuration is copied into the block only while `enable` is low.

The controller is built around four states:
- `ST_OFF`: the block is disabled.
- `ST_SYNC`: the synchronization quantum.
- `ST_TSEG1`: the first time segment.
- `ST_TSEG2`: the second time segment.

The transitions are:
- enable-start: `ST_OFF` to `ST_SYNC`.
- sync-done: `ST_SYNC` to `ST_TSEG1` on a tick.
- sample-point: `ST_TSEG1` to `ST_TSEG2` when the segment counter reaches its limit.
- bit-end: `ST_TSEG2` to `ST_SYNC` when the segment counter reaches its limit.
- hard-sync: any running state to `ST_SYNC`.
- disable: any state to `ST_OFF`.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is asserted and after its release, `sample_stb` and `tx_stb` are 0 and `sample_bit` is 1. No `tx_stb` appears while `enable` is low.
- R2: Configuration inputs are captured only while `enable` is low. A change made while enabled leaves the bit length unchanged.
- R3: `enable` may be seen high at a clock edge while the block is off. At that edge `tx_stb` is asserted and a new bit begins with its synchronization quantum.
- R4: One tq lasts `cfg_brp`+1 clocks, where `cfg_brp` is 6 bits encoded as value minus one. A bit without edges lasts (1+T1+T2) tq. T1 is `cfg_tseg1`+1 and ranges over 4..16, with `cfg_tseg1` 4 bits. T2 is `cfg_tseg2`+1 and ranges over 2..8, with `cfg_tseg2` 3 bits.
- R5: `sample_stb` rises (1+T1) tq after `tx_stb`, which is the end of the first time segment. `sample_bit` then holds the synchronized receive value.
- R6: The receive input passes through two flops. A falling edge driven just before clock edge k is classified in the tq that is current after edge k+1. With a divide of 1, an edge driven d clocks after the `tx_stb` edge therefore falls at bit position e = d+2, where position 0 is the synchronization quantum.
- R7: A late edge falls in the first segment at position e, with 1 ≤ e ≤ T1. It lengthens that segment by min(e, SJW) tq, where SJW is `cfg_sjw`+1 and ranges over 1..4.
- R8: An early edge falls in the second segment at position e, leaving r = N-1-e quanta after the current one, where N = 1+T1+T2. It shortens that segment by min(r, SJW). When r ≤ SJW the next bit starts at the end of the current quantum.
- R9: With `bus_idle` high, a falling edge restarts the bit: `tx_stb` is asserted three clocks after the edge is driven and the prescaler restarts. `sample_stb` follows (1+T1) tq later.
- R10: At most one resynchronization is applied per bit. A second falling edge in the same bit has no effect.
- R11: Dominant-to-recessive transitions never change bit timing.
- R12: `sample_stb` and `tx_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the timing; while low, configuration is captured |
| bus_idle | input | 1 | High selects hard synchronization on falling edges |
| rx_in | input | 1 | Receive line, asynchronous, 1 = recessive |
| cfg_brp | input | 6 | Prescaler divide minus one |
| cfg_tseg1 | input | 4 | First time segment length minus one |
| cfg_tseg2 | input | 3 | Second time segment length minus one |
| cfg_sjw | input | 2 | Jump width minus one |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Bit value read at the last sample point |
| tx_stb | output | 1 | One-clock pulse at the start of each bit |

## Verification
Two functions can land on the same tick.

The first pair is a late edge and the sample point. An edge at position e = T1 is classified on the very tick that would otherwise end the first segment. The extension must win, and the sample strobe must move by min(T1, SJW) quanta rather than fire on time.

The second pair is an early edge and the bit end. An edge in the last quantum of the second segment coincides with the natural bit end and must leave the bit length at N.

The bench places falling edges at every position from 2 to N-1 for each jump width. It judges the result by the clock distance between successive strobes.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    localparam int BRP_W_DEF = 6;
    localparam int TS1_W_DEF = 4;
    localparam int TS2_W_DEF = 3;
    localparam int SJW_W_DEF = 2;
    localparam int SYNC_STAGES_DEF = 2;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SYNC  = 2'd1,
        ST_TSEG1 = 2'd2,
        ST_TSEG2 = 2'd3
    } cbt_state_e;
endpackage

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_s,
    output logic rx_fall
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-1:0], rx_in};
    end

    assign rx_s    = sh[STAGES-1];
    assign rx_fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/cbt_tq_prescaler.sv
module cbt_tq_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);
    logic [BRP_W-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) pcnt <= '0;
        else if (pcnt == brp)  pcnt <= '0;
        else                   pcnt <= pcnt + 1'b1;
    end

    assign tick = (pcnt == brp);

    // R4
    pcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= brp);
endmodule

// File: rtl/cbt_bit_fsm.sv
module cbt_bit_fsm
    import cbt_pkg::*;
#(
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int SJW_W = 2,
    localparam int CNT_W = $clog2((1 << TS1_W) + (1 << SJW_W))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bus_idle,
    input  logic             tick,
    input  logic             rx_fall,
    input  logic             rx_s,
    input  logic [TS1_W-1:0] t1m1,
    input  logic [TS2_W-1:0] t2m1,
    input  logic [SJW_W-1:0] sjwm1,
    output logic             restart,
    output logic             sample_stb,
    output logic             sample_bit,
    output logic             tx_stb
);
    cbt_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim1_q, lim1_d, lim2_q, lim2_d;
    logic             used_q, used_d, pend_q, pend_d;

    logic             ev, hard, resync, end1, end2;
    logic [CNT_W-1:0] sjw, err_late, err_early, adj_late, adj_early;
    logic [CNT_W-1:0] lim1_eff, lim2_eff;

    // phase error and effective segment limits
    always_comb begin
        sjw       = CNT_W'(sjwm1) + CNT_W'(1);
        ev        = rx_fall | pend_q;
        hard      = enable && (state_q != ST_OFF) && bus_idle && rx_fall;
        resync    = enable && tick && ev && !used_q && !bus_idle && (state_q != ST_OFF);
        err_late  = cnt_q + CNT_W'(1);
        err_early = CNT_W'(t2m1) - cnt_q;
        adj_late  = (err_late  < sjw) ? err_late  : sjw;
        adj_early = (err_early < sjw) ? err_early : sjw;
        lim1_eff  = (resync && state_q == ST_TSEG1) ? CNT_W'(t1m1) + adj_late : lim1_q;
        lim2_eff  = (resync && state_q == ST_TSEG2) ? CNT_W'(t2m1) - adj_early : lim2_q;
        end1      = tick && (state_q == ST_TSEG1) && (cnt_q >= lim1_eff);
        end2      = tick && (state_q == ST_TSEG2) && (cnt_q >= lim2_eff);
        restart   = !enable || (state_q == ST_OFF) || hard;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim1_d  = lim1_q;
        lim2_d  = lim2_q;
        used_d  = used_q | resync;
        pend_d  = (tick || hard || state_q == ST_OFF) ? 1'b0 : (pend_q | rx_fall);
        if (!enable) begin
            state_d = ST_OFF;
            cnt_d   = '0;
            used_d  = 1'b0;
            pend_d  = 1'b0;
        end else if (hard) begin
            state_d = ST_SYNC;
            cnt_d   = '0;
            used_d  = 1'b1;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_SYNC;
                    cnt_d   = '0;
                    used_d  = 1'b0;
                end
                ST_SYNC: begin
                    if (tick) begin
                        state_d = ST_TSEG1;
                        cnt_d   = '0;
                        lim1_d  = CNT_W'(t1m1);
                    end
                end
                ST_TSEG1: begin
                    if (end1) begin
                        state_d = ST_TSEG2;
                        cnt_d   = '0;
                        lim2_d  = CNT_W'(t2m1);
                    end else if (tick) begin
                        cnt_d  = cnt_q + CNT_W'(1);
                        lim1_d = lim1_eff;
                    end
                end
                ST_TSEG2: begin
                    if (end2) begin
                        state_d = ST_SYNC;
                        cnt_d   = '0;
                        used_d  = 1'b0;
                    end else if (tick) begin
                        cnt_d  = cnt_q + CNT_W'(1);
                        lim2_d = lim2_eff;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            lim1_q  <= '0;
            lim2_q  <= '0;
            used_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim1_q  <= lim1_d;
            lim2_q  <= lim2_d;
            used_q  <= used_d;
            pend_q  <= pend_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            sample_bit <= 1'b1;
            tx_stb     <= 1'b0;
        end else begin
            sample_stb <= enable && !hard && end1;
            if (enable && !hard && end1) sample_bit <= rx_s;
            tx_stb     <= enable && (hard || state_q == ST_OFF || end2);
        end
    end

    // R12
    strobes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_stb && sample_stb));

    // R3
    tx_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> (state_q == ST_SYNC && cnt_q == '0));

    // R5
    sample_at_ts2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (state_q == ST_TSEG2 && cnt_q == '0));

    // R7
    ts1_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TSEG1) |-> (cnt_q <= CNT_W'(t1m1) + sjw));

    // R10
    ext_marks_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TSEG1 && lim1_q != CNT_W'(t1m1)) |-> used_q);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import cbt_pkg::*;
#(
    parameter int BRP_W       = BRP_W_DEF,
    parameter int TS1_W       = TS1_W_DEF,
    parameter int TS2_W       = TS2_W_DEF,
    parameter int SJW_W       = SJW_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bus_idle,
    input  logic             rx_in,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [TS1_W-1:0] cfg_tseg1,
    input  logic [TS2_W-1:0] cfg_tseg2,
    input  logic [SJW_W-1:0] cfg_sjw,
    output logic             sample_stb,
    output logic             sample_bit,
    output logic             tx_stb
);
    logic [BRP_W-1:0] brp_q;
    logic [TS1_W-1:0] t1m1_q;
    logic [TS2_W-1:0] t2m1_q;
    logic [SJW_W-1:0] sjwm1_q;
    logic             rx_s, rx_fall, tick, restart;

    // configuration shadow, loaded only while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brp_q   <= '0;
            t1m1_q  <= TS1_W'(3);
            t2m1_q  <= TS2_W'(1);
            sjwm1_q <= '0;
        end else if (!enable) begin
            brp_q   <= cfg_brp;
            t1m1_q  <= cfg_tseg1;
            t2m1_q  <= cfg_tseg2;
            sjwm1_q <= cfg_sjw;
        end
    end

    cbt_rx_sync #(.STAGES(SYNC_STAGES)) i_rx_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_in   (rx_in),
        .rx_s    (rx_s),
        .rx_fall (rx_fall)
    );

    cbt_tq_prescaler #(.BRP_W(BRP_W)) i_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .brp     (brp_q),
        .tick    (tick)
    );

    cbt_bit_fsm #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .bus_idle   (bus_idle),
        .tick       (tick),
        .rx_fall    (rx_fall),
        .rx_s       (rx_s),
        .t1m1       (t1m1_q),
        .t2m1       (t2m1_q),
        .sjwm1      (sjwm1_q),
        .restart    (restart),
        .sample_stb (sample_stb),
        .sample_bit (sample_bit),
        .tx_stb     (tx_stb)
    );
endmodule

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       bus_idle = 1'b0;
    logic       rx_in = 1'b1;
    logic [5:0] cfg_brp = '0;
    logic [3:0] cfg_tseg1 = 4'd5;
    logic [2:0] cfg_tseg2 = 3'd3;
    logic [1:0] cfg_sjw = '0;
    logic       sample_stb, sample_bit, tx_stb;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int tx_cnt = 0, smp_cnt = 0;
    int last_tx = 0, last_smp = 0;
    logic last_bit = 1'b1;

    always #2 clk = ~clk;

    can_bit_timer i_can_bit_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bus_idle(bus_idle),
        .rx_in(rx_in), .cfg_brp(cfg_brp), .cfg_tseg1(cfg_tseg1),
        .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw),
        .sample_stb(sample_stb), .sample_bit(sample_bit), .tx_stb(tx_stb)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // event monitor, away from the active edge
    always @(negedge clk) begin
        if (tx_stb) begin tx_cnt++; last_tx = cyc; end
        if (sample_stb) begin smp_cnt++; last_smp = cyc; last_bit = sample_bit; end
        if (tx_stb && sample_stb) begin
            miscompares++;
            $display("FAIL R12 both strobes high: actual=1 expected=0");
        end
    end

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tx(output int c);
        int s0 = tx_cnt;
        int n = 0;
        while (tx_cnt == s0 && n < 3000) begin step(); n++; end
        if (tx_cnt == s0) begin
            miscompares++;
            $display("FAIL watchdog tx_stb: actual=none expected=pulse");
        end
        c = last_tx;
    endtask

    task automatic wait_smp(output int c);
        int s0 = smp_cnt;
        int n = 0;
        while (smp_cnt == s0 && n < 3000) begin step(); n++; end
        if (smp_cnt == s0) begin
            miscompares++;
            $display("FAIL watchdog sample_stb: actual=none expected=pulse");
        end
        c = last_smp;
    endtask

    task automatic configure(int brp, int t1, int t2, int sjw);
        enable = 1'b0;
        step();
        cfg_brp   = 6'(brp - 1);
        cfg_tseg1 = 4'(t1 - 1);
        cfg_tseg2 = 3'(t2 - 1);
        cfg_sjw   = 2'(sjw - 1);
        step();
        step();
    endtask

    initial begin
        #800000;
        miscompares++;
        $display("FAIL watchdog global: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int p, t, s, q, c0, nb;
        // R1 reset state
        repeat (3) step();
        chk("R1 tx_stb in reset", int'(tx_stb), 0);
        chk("R1 sample_stb in reset", int'(sample_stb), 0);
        chk("R1 sample_bit in reset", int'(sample_bit), 1);
        rst_n = 1'b1;
        repeat (20) step();
        chk("R1 no tx while disabled", tx_cnt, 0);
        chk("R1 sample_bit after reset", int'(sample_bit), 1);

        // R3 R4 R5 sweep of prescaler and segment lengths
        for (int brp = 1; brp <= 3; brp++) begin
            for (int t1 = 4; t1 <= 16; t1++) begin
                for (int t2 = 2; t2 <= 8; t2++) begin
                    configure(brp, t1, t2, 1);
                    c0 = cyc;
                    enable = 1'b1;
                    wait_tx(p);
                    chk("R3 first tx latency", p - c0, 1);
                    wait_smp(s);
                    chk("R5 sample offset", s - p, (1 + t1) * brp);
                    chk("R5 sample_bit recessive", int'(last_bit), 1);
                    wait_tx(t);
                    chk("R4 bit length", t - p, (1 + t1 + t2) * brp);
                end
            end
        end

        // R6 R7 R8 R11 resync sweep, divide 1, T1=6, T2=4
        for (int sjw = 1; sjw <= 4; sjw++) begin
            configure(1, 6, 4, sjw);
            enable = 1'b1;
            nb = 11;
            for (int e = 2; e <= nb - 1; e++) begin
                wait_tx(p);
                repeat (e - 2) step();
                rx_in = 1'b0;
                if (e <= 6) begin
                    wait_smp(s);
                    chk("R7 R6 late sample shift", s - p, 7 + imin(e, sjw));
                    wait_tx(t);
                    chk("R7 late bit length", t - p, nb + imin(e, sjw));
                end else begin
                    wait_tx(t);
                    chk("R8 R6 early bit length", t - p, nb - imin(nb - 1 - e, sjw));
                end
                rx_in = 1'b1;
                wait_tx(q);
                chk("R11 rising edge ignored", q - t, nb);
            end
        end

        // R10 second falling edge in the same bit is ignored
        configure(1, 6, 4, 4);
        enable = 1'b1;
        wait_tx(p);
        wait_tx(p);
        rx_in = 1'b0;
        step();
        step();
        rx_in = 1'b1;
        step();
        rx_in = 1'b0;
        wait_smp(s);
        chk("R10 one resync sample", s - p, 9);
        wait_tx(t);
        chk("R10 one resync bit", t - p, 13);
        rx_in = 1'b1;
        wait_tx(p);
        wait_tx(t);
        chk("R10 following bit nominal", t - p, 11);

        // R2 configuration change while enabled has no effect
        wait_tx(p);
        cfg_tseg1 = 4'd15;
        cfg_tseg2 = 3'd7;
        cfg_brp   = 6'd2;
        wait_tx(t);
        chk("R2 cfg ignored bit 1", t - p, 11);
        wait_tx(q);
        chk("R2 cfg ignored bit 2", q - t, 11);

        // R9 hard synchronization on idle bus
        for (int brp = 1; brp <= 4; brp += 3) begin
            for (int d = 0; d <= 4; d++) begin
                configure(brp, 5, 3, 1);
                bus_idle = 1'b1;
                enable = 1'b1;
                wait_tx(p);
                repeat (d) step();
                rx_in = 1'b0;
                c0 = cyc;
                wait_tx(t);
                chk("R9 hard sync tx latency", t - c0, 3);
                wait_smp(s);
                chk("R9 hard sync sample", s - c0, 3 + 6 * brp);
                chk("R5 R9 sample_bit dominant", int'(last_bit), 0);
                rx_in = 1'b1;
                wait_tx(q);
                chk("R9 R11 bit after hard sync", q - t, 9 * brp);
                bus_idle = 1'b0;
            end
        end

        enable = 1'b0;
        repeat (4) step();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule